// File: doc/BRIEF.md
# Stepped Regulator Setpoint Loader

This block sets a core-supply regulator over a three-wire serial link made of a data line, a shift clock and a load strobe. A requester offers a target core frequency in kHz. The block converts that frequency to a 12-bit regulator code and walks the regulator toward the code one frame at a time. While the code it holds is more than one step (0x100) away from the target, each frame moves it by exactly one step. This keeps the supply from swinging far enough in one jump to make the regulator cut out. A force flag on the request skips the walk: the target code goes out in a single frame. The force flag is used to put the regulator into a known state right after reset.

Each frame sends the code most significant bit first. Every bit spends one delay unit with the clock low and one delay unit with the clock high. After the last bit comes one delay unit of gap with everything low, then the load strobe is high for one delay unit to latch the frame. The delay unit is a whole number of system clocks.

The request side is a valid/ready input. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. While the block is busy, the requester must hold its request. Anything offered during that time is not taken and has no effect. `done` pulses once when the last frame of a request has been latched.

Top module: `vreg_step_loader`

## Requirements
- R1: The request frequency maps to a code: below 200000 kHz gives 0xFFF; 200000 to 299999 kHz gives 0xDE5; 300000 kHz and above gives 0x325. The last frame of every request carries that code.
- R2: Without force, a frame carries the held code plus 0x100 if that sum is still below the target. It carries the held code minus 0x100 if the held code is more than 0x100 above the target. Otherwise it carries the target itself.
- R3: With force, the first frame carries the target code, so a forced request produces exactly one frame. The force flag is cleared after that frame.
- R4: Each frame shifts exactly 12 bits, bit 11 first and bit 0 last. The bench captures `ser_data` on each rise of `ser_clk`, and `ser_data` is stable while `ser_clk` is high.
- R5: Inside a frame, `ser_clk` stays high for DELAY_CYCLES clocks per bit. `ser_ld` is high for DELAY_CYCLES clocks after the last bit. `ser_ld` and `ser_clk` are never high together.
- R6: Frames repeat until the latched code equals the target. The code the block holds is updated after each frame. A request whose target equals the held code still sends one frame.
- R7: `req_ready` equals not-`busy`. `busy` is high in the clock after a request is accepted. `done` is a one-clock pulse one clock after the last `ser_ld` falls, and `busy` drops in that same clock.
- R8: A request offered while `busy` is high is not taken and adds no frames, either during the running request or after it ends.
- R9: After reset, the held code is 0xFFF and `busy`, `done`, `ser_data`, `ser_clk` and `ser_ld` are all low. A non-forced request for a frequency below 200000 kHz made right after reset therefore sends one frame carrying 0xFFF.
- R10: All serial outputs are driven from registers and are all low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request is taken on this edge if valid |
| req_khz | input | FREQ_W (24) | Requested core frequency in kHz |
| req_force | input | 1 | Load target in one frame, without stepping |
| ser_data | output | 1 | Serial data to the regulator, MSB first |
| ser_clk | output | 1 | Serial shift clock |
| ser_ld | output | 1 | Load strobe; high pulse latches the frame |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-clock pulse when the final frame has been latched |

## Verification
`busy` is due one clock after the accepting edge. The bench drives inputs on falling edges and samples at the next falling edge. A frame lasts 26 delay units. Its bits are captured at each rise of `ser_clk` as seen at falling-edge samples. The clock-high width and the load width are counted in samples and compared with DELAY_CYCLES. The bench measures the age of the last `ser_ld` fall in samples and expects `done` when that age is exactly one. The waits are open-ended loops bounded by a timeout, because the frame count depends on the distance between codes. The expected frame sequence and count come from a bench model of the stepping rule.

// File: rtl/vreg_pkg.sv
package vreg_pkg;
  // Phases of one serial frame
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,   // data set, clock low
    PH_HIGH,  // clock high
    PH_GAP,   // all low before the latch
    PH_LOAD   // load strobe high
  } ph_e;

  // Request sequencer states
  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LAUNCH,
    SQ_WAIT
  } sq_e;
endpackage

// File: rtl/vreg_delay_timer.sv
module vreg_delay_timer #(
  parameter int DELAY_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic zero
);
  localparam int CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES + 1) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (reload)   cnt_q <= LOAD_VAL;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/vreg_code_map.sv
module vreg_code_map #(
  parameter int FREQ_W   = 24,
  parameter int CODE_W   = 12,
  parameter int LOW_KHZ  = 200000,
  parameter int HIGH_KHZ = 300000,
  parameter int CODE_LO  = 'hFFF,
  parameter int CODE_MID = 'hDE5,
  parameter int CODE_HI  = 'h325
) (
  input  logic [FREQ_W-1:0] khz,
  output logic [CODE_W-1:0] code
);
  localparam logic [FREQ_W-1:0] LIM_LO = FREQ_W'(LOW_KHZ);
  localparam logic [FREQ_W-1:0] LIM_HI = FREQ_W'(HIGH_KHZ);

  always_comb begin
    if (khz < LIM_LO)      code = CODE_W'(CODE_LO);
    else if (khz < LIM_HI) code = CODE_W'(CODE_MID);
    else                   code = CODE_W'(CODE_HI);
  end
endmodule

// File: rtl/vreg_step_calc.sv
module vreg_step_calc #(
  parameter int CODE_W = 12,
  parameter int STEP   = 256
) (
  input  logic [CODE_W-1:0] cur,
  input  logic [CODE_W-1:0] tgt,
  input  logic              force_jump,
  output logic [CODE_W-1:0] nxt
);
  localparam logic [CODE_W:0]   STEP_X = (CODE_W+1)'(STEP);
  localparam logic [CODE_W-1:0] STEP_C = CODE_W'(STEP);

  logic [CODE_W:0] cur_x, tgt_x;
  assign cur_x = {1'b0, cur};
  assign tgt_x = {1'b0, tgt};

  always_comb begin
    if (force_jump)                 nxt = tgt;
    else if (cur_x + STEP_X < tgt_x) nxt = cur + STEP_C;
    else if (cur_x > tgt_x + STEP_X) nxt = cur - STEP_C;
    else                            nxt = tgt;
  end
endmodule

// File: rtl/vreg_frame_shifter.sv
module vreg_frame_shifter
  import vreg_pkg::*;
#(
  parameter int CODE_W       = 12,
  parameter int DELAY_CYCLES = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] word,
  output logic              sdata,
  output logic              sclk,
  output logic              sld,
  output logic              frame_done
);
  localparam int IW = $clog2(CODE_W);

  ph_e               ph_q;
  logic [CODE_W-1:0] sh_q;
  logic [IW-1:0]     left_q;
  logic              tick;
  logic              reload;

  assign reload = ((ph_q == PH_IDLE) && start) || ((ph_q != PH_IDLE) && tick);

  vreg_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .reload(reload), .zero(tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      sh_q       <= '0;
      left_q     <= '0;
      sdata      <= 1'b0;
      sclk       <= 1'b0;
      sld        <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start) begin
          sh_q   <= word;
          sdata  <= word[CODE_W-1];
          sclk   <= 1'b0;
          sld    <= 1'b0;
          left_q <= IW'(CODE_W - 1);
          ph_q   <= PH_LOW;
        end
        PH_LOW: if (tick) begin
          sclk <= 1'b1;
          ph_q <= PH_HIGH;
        end
        PH_HIGH: if (tick) begin
          sclk <= 1'b0;
          if (left_q == '0) begin
            sdata <= 1'b0;
            ph_q  <= PH_GAP;
          end else begin
            left_q <= left_q - 1'b1;
            sh_q   <= {sh_q[CODE_W-2:0], 1'b0};
            sdata  <= sh_q[CODE_W-2];
            ph_q   <= PH_LOW;
          end
        end
        PH_GAP: if (tick) begin
          sld  <= 1'b1;
          ph_q <= PH_LOAD;
        end
        PH_LOAD: if (tick) begin
          sld        <= 1'b0;
          frame_done <= 1'b1;
          ph_q       <= PH_IDLE;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vreg_step_loader.sv
module vreg_step_loader
  import vreg_pkg::*;
#(
  parameter int FREQ_W       = 24,
  parameter int CODE_W       = 12,
  parameter int STEP         = 256,
  parameter int DELAY_CYCLES = 50,
  parameter int LOW_KHZ      = 200000,
  parameter int HIGH_KHZ     = 300000,
  parameter int CODE_LO      = 'hFFF,
  parameter int CODE_MID     = 'hDE5,
  parameter int CODE_HI      = 'h325,
  parameter int RESET_CODE   = 'hFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FREQ_W-1:0] req_khz,
  input  logic              req_force,
  output logic              ser_data,
  output logic              ser_clk,
  output logic              ser_ld,
  output logic              busy,
  output logic              done
);
  sq_e               st_q;
  logic [CODE_W-1:0] cur_q, tgt_q, frame_q;
  logic              force_q;
  logic [CODE_W-1:0] map_code, step_code;
  logic              frame_done;

  vreg_code_map #(
    .FREQ_W(FREQ_W), .CODE_W(CODE_W), .LOW_KHZ(LOW_KHZ), .HIGH_KHZ(HIGH_KHZ),
    .CODE_LO(CODE_LO), .CODE_MID(CODE_MID), .CODE_HI(CODE_HI)
  ) u_map (
    .khz(req_khz), .code(map_code)
  );

  vreg_step_calc #(.CODE_W(CODE_W), .STEP(STEP)) u_step (
    .cur(cur_q), .tgt(tgt_q), .force_jump(force_q), .nxt(step_code)
  );

  vreg_frame_shifter #(.CODE_W(CODE_W), .DELAY_CYCLES(DELAY_CYCLES)) u_shf (
    .clk(clk), .rst_n(rst_n),
    .start(st_q == SQ_LAUNCH), .word(step_code),
    .sdata(ser_data), .sclk(ser_clk), .sld(ser_ld),
    .frame_done(frame_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      cur_q   <= CODE_W'(RESET_CODE);
      tgt_q   <= CODE_W'(RESET_CODE);
      frame_q <= '0;
      force_q <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        SQ_IDLE: if (req_valid) begin
          tgt_q   <= map_code;
          force_q <= req_force;
          busy    <= 1'b1;
          st_q    <= SQ_LAUNCH;
        end
        SQ_LAUNCH: begin
          frame_q <= step_code;
          force_q <= 1'b0;
          st_q    <= SQ_WAIT;
        end
        SQ_WAIT: if (frame_done) begin
          cur_q <= frame_q;
          if (frame_q == tgt_q) begin
            busy <= 1'b0;
            done <= 1'b1;
            st_q <= SQ_IDLE;
          end else begin
            st_q <= SQ_LAUNCH;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign req_ready = !busy;
endmodule

// File: rtl/vreg_step_loader_chk.sv
module vreg_step_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ser_data,
  input logic ser_clk,
  input logic ser_ld,
  input logic busy,
  input logic done
);
  // R5
  ld_clk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_ld |-> !ser_clk);

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_clk |-> $stable(ser_data));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_clk && !ser_ld && !ser_data));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
endmodule

bind vreg_step_loader vreg_step_loader_chk u_chk (.*);

// File: tb/sim_vreg_step_loader.sv
module sim_vreg_step_loader;
  localparam int D  = 4;
  localparam int WD = 40000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_force = 1'b0;
  logic [23:0] req_khz = '0;
  wire         req_ready, ser_data, ser_clk, ser_ld, busy, done;

  vreg_step_loader #(.DELAY_CYCLES(D)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_khz(req_khz), .req_force(req_force), .ser_data(ser_data),
    .ser_clk(ser_clk), .ser_ld(ser_ld), .busy(busy), .done(done)
  );

  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {khz, force, final code}
  localparam logic [36:0] VEC [8] = '{
    {24'd100000,  1'b0, 12'hFFF},   // R9 first request after reset
    {24'd250000,  1'b0, 12'hDE5},
    {24'd300000,  1'b0, 12'h325},
    {24'd199999,  1'b0, 12'hFFF},
    {24'd200000,  1'b1, 12'hDE5},
    {24'd299999,  1'b0, 12'hDE5},   // equal target, one frame
    {24'd4000000, 1'b1, 12'h325},
    {24'd0,       1'b0, 12'hFFF}
  };

  // Serial monitor
  logic [11:0] frames [64];
  int          fbits  [64];
  int          nfr = 0;
  logic [11:0] sh = '0;
  int          nbits = 0, hi_len = 0, ld_len = 0, fall_age = 100;
  bit          pclk = 1'b0, pld = 1'b0;

  always @(negedge clk) if (rst_n) begin
    if (ser_clk && !pclk) begin
      sh = {sh[10:0], ser_data};
      nbits++;
      hi_len = 0;
    end
    if (ser_clk) hi_len++;
    if (!ser_clk && pclk) chk(hi_len == D, "R5 clock high width", hi_len, D);
    if (ser_ld && !pld) begin
      if (nfr < 64) begin
        frames[nfr] = sh;
        fbits[nfr]  = nbits;
      end
      nfr++;
      nbits  = 0;
      ld_len = 0;
    end
    if (ser_ld) ld_len++;
    if (!ser_ld && pld) begin
      chk(ld_len == D, "R5 load width", ld_len, D);
      fall_age = 0;
    end else begin
      fall_age++;
    end
    if (done) chk(fall_age == 1, "R7 done one clock after load falls", fall_age, 1);
    pclk = ser_clk;
    pld  = ser_ld;
  end

  // Bench model of the requirements
  logic [11:0] mcur = 12'hFFF;  // R9 held code after reset

  function automatic logic [11:0] m_code(input int k);
    if (k < 200000) return 12'hFFF;
    else if (k < 300000) return 12'hDE5;
    return 12'h325;
  endfunction

  function automatic logic [11:0] m_next(input logic [11:0] c, input logic [11:0] t);
    int ci = int'(c);
    int ti = int'(t);
    if (ci + 256 < ti) return c + 12'h100;
    if (ci > ti + 256) return c - 12'h100;
    return t;
  endfunction

  task automatic wait_done();
    int cyc = 0;
    while (!done && cyc < WD) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= WD) chk(1'b0, "watchdog waiting for done", cyc, WD);
  endtask

  task automatic run_req(input int khz, input bit frc, input logic [11:0] exp_code,
                         input bit spam);
    logic [11:0] c, t, e;
    int k;
    nfr = 0;
    @(negedge clk);
    req_khz = 24'(khz); req_force = frc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7 busy after accept", busy, 1);
    chk(req_ready == 1'b0, "R7 ready low while busy", req_ready, 0);
    if (spam) begin
      for (int i = 0; i < 3; i++) begin
        req_khz = 24'd100000; req_force = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b0, "R8 request held off while busy", req_ready, 0);
      end
      req_valid = 1'b0;
    end
    wait_done();
    @(negedge clk);
    chk(busy == 1'b0, "R7 busy low after done", busy, 0);
    t = m_code(khz);
    c = mcur;
    k = 0;
    do begin
      e = (k == 0 && frc) ? t : m_next(c, t);
      if (k < nfr && k < 64) begin
        chk(frames[k] == e, frc ? "R3 forced frame code" : "R2 step frame code",
            int'(frames[k]), int'(e));
        chk(fbits[k] == 12, "R4 bits per frame", fbits[k], 12);
      end
      c = e;
      k++;
    end while (c != t && k < 64);
    chk(nfr == k, "R6 frame count", nfr, k);
    if (nfr > 0 && nfr <= 64)
      chk(frames[nfr-1] == exp_code, "R1 final code", int'(frames[nfr-1]), int'(exp_code));
    else
      chk(1'b0, "R1 final code missing", nfr, k);
    mcur = t;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 / R10 reset state
    chk(busy == 1'b0, "R9 busy after reset", busy, 0);
    chk(done == 1'b0, "R9 done after reset", done, 0);
    chk(req_ready == 1'b1, "R7 ready after reset", req_ready, 1);
    chk({ser_data, ser_clk, ser_ld} == 3'b000, "R10 serial pins after reset",
        int'({ser_data, ser_clk, ser_ld}), 0);

    for (int i = 0; i < 8; i++)
      run_req(int'(VEC[i][36:13]), VEC[i][12], VEC[i][11:0], 1'b0);

    // R8: requests offered while busy are not taken
    run_req(300000, 1'b0, 12'h325, 1'b1);
    repeat (200) @(negedge clk);
    chk(nfr == 13, "R8 no frames after ignored requests", nfr, 13);
    chk({ser_data, ser_clk, ser_ld} == 3'b000, "R10 pins low while idle",
        int'({ser_data, ser_clk, ser_ld}), 0);

    finish_run();
  end

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end
endmodule